// File: doc/BRIEF.md
# Two-Bank Interleaved Word Memory

This block is a 16-word by 2-bit synchronous memory assembled from two identical 8-word by 2-bit banks. The banks share the write data and the read data path. Each bank receives its own 3-bit local address and its own derived enable. A configuration input, `map_sel`, chooses how the 4-bit system address is split across the two banks.

In contiguous mode the top address bit picks the bank, so each bank holds one unbroken half of the address space. In even/odd mode the bottom address bit picks the bank, so consecutive addresses alternate between the banks. In both modes the address bits that remain form the local address inside the bank. Only the selected bank is enabled on an access. The other bank sees nothing.

Writes are gated by a global chip enable together with a write enable. Reads are gated by the chip enable together with an output enable. Read data appears one clock after the request and is zero when no read was requested.

Top module: `ilv_mem_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rdata` is 0.
- R2: With `map_sel`=0 (contiguous), bank 0 serves addresses 0..7 and bank 1 serves 8..15. The bank is `addr[3]` and the local address is `addr[2:0]`.
- R3: With `map_sel`=1 (even/odd), bank 0 serves even addresses and bank 1 serves odd addresses. The bank is `addr[0]` and the local address is `addr[3:1]`.
- R4: A clock edge stores `wdata` only when `ce` and `we` are both 1. It writes only the selected bank at its local address. With `ce`=0 a raised `we` changes nothing.
- R5: When `ce` and `oe` are both 1 at a clock edge, `rdata` holds the addressed word from that edge until the next edge.
- R6: When `ce` or `oe` is 0 at a clock edge, `rdata` is 0 after that edge.
- R7: A read and a write to the same address at the same edge return the word as it was before the write.
- R8: While `ce` is 1, exactly one bank enable is active. While `ce` is 0, none is active.
- R9: Stored words stay where they are when `map_sel` changes. A word written in one mode is found at the address that the other mode maps to the same bank and local address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_sel | input | 1 | Address map select: 0 contiguous halves, 1 even/odd interleave |
| addr | input | 4 | System word address |
| wdata | input | 2 | Write data |
| we | input | 1 | Write enable |
| ce | input | 1 | Global chip enable |
| oe | input | 1 | Global output enable |
| rdata | output | 2 | Read data, one cycle after the request, 0 when idle |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. This holds for a read word, the zero after an idle or masked cycle, and the old word on a same-address read and write.

The driver applies one access per falling edge and queues the value expected after the following rising edge. The monitor pops one entry a short delay after each rising edge, so each comparison lands in the cycle its result belongs to.

Bank placement is checked at the ports. Words are written under one address map and read back under the other.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {
    MAP_CONTIG   = 1'b0,
    MAP_EVEN_ODD = 1'b1
  } map_mode_e;

  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/ilv_addr_map.sv
module ilv_addr_map
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int LOC_W = ADDR_W - 1
) (
  input  map_mode_e             mode,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  ce,
  output logic [NUM_BANKS-1:0]  bank_en,
  output logic                  bank_idx,
  output logic [LOC_W-1:0]      loc_addr
);
  always_comb begin
    unique case (mode)
      MAP_CONTIG: begin
        bank_idx = addr[ADDR_W-1];
        loc_addr = addr[ADDR_W-2:0];
      end
      default: begin
        bank_idx = addr[0];
        loc_addr = addr[ADDR_W-1:1];
      end
    endcase
  end

  // One enable per bank, gated by the global chip enable
  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_en
      assign bank_en[b] = ce && (bank_idx == b[0]);
    end
  endgenerate
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int LOC_W  = 3,
  parameter int DATA_W = 2,
  localparam int DEPTH = 2 ** LOC_W
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [LOC_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Read-first single-port RAM, no reset on the array
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      q <= mem[addr];
    end
  end
endmodule

// File: rtl/ilv_rd_sel.sv
module ilv_rd_sel
  import ilv_pkg::*;
#(
  parameter int DATA_W = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rd_req,
  input  logic                             bank_idx,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q,
  output logic [DATA_W-1:0]                rdata
);
  logic rd_vld;
  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      rd_vld <= rd_req;
      sel_q  <= bank_idx;
    end
  end

  assign rdata = rd_vld ? bank_q[sel_q] : '0;
endmodule

// File: rtl/ilv_mem_top.sv
module ilv_mem_top
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              map_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              ce,
  input  logic              oe,
  output logic [DATA_W-1:0] rdata
);
  localparam int LOC_W = ADDR_W - 1;

  logic [NUM_BANKS-1:0]             bank_en;
  logic                             bank_idx;
  logic [LOC_W-1:0]                 loc_addr;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q;

  ilv_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .mode     (map_mode_e'(map_sel)),
    .addr     (addr),
    .ce       (ce),
    .bank_en  (bank_en),
    .bank_idx (bank_idx),
    .loc_addr (loc_addr)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      ilv_bank #(.LOC_W(LOC_W), .DATA_W(DATA_W)) u_bank (
        .clk   (clk),
        .en    (bank_en[b]),
        .we    (we),
        .addr  (loc_addr),
        .wdata (wdata),
        .q     (bank_q[b])
      );
    end
  endgenerate

  ilv_rd_sel #(.DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (ce && oe),
    .bank_idx (bank_idx),
    .bank_q   (bank_q),
    .rdata    (rdata)
  );
endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              map_sel,
  input logic [ADDR_W-1:0] addr,
  input logic              ce,
  input logic              oe,
  input logic [1:0]        bank_en,
  input logic [DATA_W-1:0] rdata
);
  p_one_bank_r8: assert property (@(posedge clk) disable iff (rst)
    ce |-> $countones(bank_en) == 1);

  p_no_bank_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !ce |-> bank_en == 2'b00);

  p_contig_select_r2: assert property (@(posedge clk) disable iff (rst)
    (ce && !map_sel) |-> bank_en[addr[ADDR_W-1]]);

  p_evenodd_select_r3: assert property (@(posedge clk) disable iff (rst)
    (ce && map_sel) |-> bank_en[addr[0]]);

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !(ce && oe) |=> rdata == '0);
endmodule

bind ilv_mem_top ilv_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .map_sel (map_sel),
  .addr    (addr),
  .ce      (ce),
  .oe      (oe),
  .bank_en (bank_en),
  .rdata   (rdata)
);

// File: tb/ilv_mem_top_tb.sv
module ilv_mem_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       map_sel = 1'b0;
  logic [3:0] addr = '0;
  logic [1:0] wdata = '0;
  logic       we = 1'b0;
  logic       ce = 1'b0;
  logic       oe = 1'b0;
  logic [1:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference storage: [bank][local]
  logic [1:0] model [2][8];

  logic [1:0] exp_q [$];
  string      tag_q [$];
  logic [3:0] adr_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_mem_top u_dut (
    .clk(clk), .rst(rst), .map_sel(map_sel), .addr(addr), .wdata(wdata),
    .we(we), .ce(ce), .oe(oe), .rdata(rdata)
  );

  function automatic int bank_of(input logic m, input logic [3:0] a);
    return m ? int'(a[0]) : int'(a[3]);          // R2 / R3 map
  endfunction

  function automatic int loc_of(input logic m, input logic [3:0] a);
    return m ? int'(a[3:1]) : int'(a[2:0]);
  endfunction

  function automatic logic [1:0] pat(input logic [3:0] a, input int p);
    return a[3:2] ^ a[1:0] ^ 2'(p);
  endfunction

  // Driver: one access per falling edge, expected result queued
  task automatic access(input logic m, input logic [3:0] a, input logic [1:0] d,
                        input logic w, input logic c, input logic o, input string tag);
    logic [1:0] e;
    @(negedge clk);
    map_sel = m; addr = a; wdata = d; we = w; ce = c; oe = o;
    e = (c && o) ? model[bank_of(m, a)][loc_of(m, a)] : 2'b00;
    if (c && w) model[bank_of(m, a)][loc_of(m, a)] = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    adr_q.push_back(a);
  endtask

  task automatic idle();
    access(1'b0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, "R6");
  endtask

  // Monitor: compares one cycle after each queued access
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      logic [3:0] a;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = adr_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s addr=%0d rdata=%0d expected=%0d", t, a, rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired rdata=%0d expected=done", rdata);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;                                       // R1 during reset
    if (rdata !== 2'b00) begin
      errors++;
      $display("FAIL R1 rdata=%0d expected=0", rdata);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;                                       // R1 first cycle after
    if (rdata !== 2'b00) begin
      errors++;
      $display("FAIL R1 rdata=%0d expected=0", rdata);
    end

    // R2 / R3 / R5: fill and read back in each mode with two patterns
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 2; p++) begin
        for (int a = 0; a < 16; a++)
          access(1'(m), 4'(a), pat(4'(a), p + 2*m), 1'b1, 1'b1, 1'b0, "R4");
        for (int a = 0; a < 16; a++)
          access(1'(m), 4'(a), 2'd0, 1'b0, 1'b1, 1'b1, m ? "R3_R5" : "R2_R5");
      end
    end

    // R9: write in contiguous mode, read in even/odd mode, and the reverse
    for (int a = 0; a < 16; a++)
      access(1'b0, 4'(a), pat(4'(a), 1), 1'b1, 1'b1, 1'b0, "R4");
    for (int a = 0; a < 16; a++)
      access(1'b1, 4'(a), 2'd0, 1'b0, 1'b1, 1'b1, "R9");
    for (int a = 0; a < 16; a++)
      access(1'b1, 4'(a), pat(4'(a), 3), 1'b1, 1'b1, 1'b0, "R4");
    for (int a = 0; a < 16; a++)
      access(1'b0, 4'(a), 2'd0, 1'b0, 1'b1, 1'b1, "R9");

    // R4: write enable with chip disabled is ignored
    access(1'b0, 4'd5, ~model[0][5], 1'b1, 1'b0, 1'b1, "R4");
    access(1'b0, 4'd5, 2'd0, 1'b0, 1'b1, 1'b1, "R4");
    access(1'b1, 4'd12, ~model[0][6], 1'b1, 1'b0, 1'b0, "R4");
    access(1'b1, 4'd12, 2'd0, 1'b0, 1'b1, 1'b1, "R4");

    // R6: masked reads return zero
    access(1'b0, 4'd9, 2'd0, 1'b0, 1'b1, 1'b0, "R6");
    access(1'b1, 4'd9, 2'd0, 1'b0, 1'b0, 1'b1, "R6");
    idle();

    // R7: same-address read and write returns old word, then the new one
    access(1'b0, 4'd10, ~model[1][2], 1'b1, 1'b1, 1'b1, "R7");
    access(1'b0, 4'd10, 2'd0, 1'b0, 1'b1, 1'b1, "R7");
    access(1'b1, 4'd7, ~model[1][3], 1'b1, 1'b1, 1'b1, "R7");
    access(1'b1, 4'd7, 2'd0, 1'b0, 1'b1, 1'b1, "R7");
    idle();

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule